// File: doc/BRIEF.md
# Threshold-Gated Interrupt Bid Arbiter

This block sits at the interrupt side of a two-channel serial controller. Each cycle it collects a bid from every interrupt source and finds the largest. The sources are, per channel, a receiver, a transmitter, change of state, address match, flow-control status, break change and loopback error, plus two counter/timers. A bid is an 11-bit value: an 8-bit priority on top and a 3-bit code below it. Receivers and transmitters supply their own priority. Every other source type takes its priority from a bidding register that software writes.

The registered winner drives an active-low interrupt request. The request asserts only when the winner's priority is strictly greater than a programmable threshold. While any receive watchdog is pending, only receiver bids take part and the threshold is ignored. This lets a receiver that holds only a few characters still reach the host.

An interrupt acknowledge pulse, or a write of any data to the update-command address, freezes the winner into an 8-bit current-interrupt byte. That byte tells a service routine what to handle. It holds its value until the next acknowledge or update, while arbitration goes on underneath.

Top module: `irq_bid_arbiter`

## Requirements
- R1: After reset, `irq_n` is 1, `cur_irq` is 0x00, the threshold is 0 and every bidding register is 0. A source whose bidding register is still 0 never wins.
- R2: Each bid key is {priority[7:0], code[2:0]}, with these codes: receiver {11,ch}, transmitter {10,ch}, other channel sources {00,ch}, counter/timer k {00,k}. Receiver and transmitter priorities come from their input ports. The other priorities come from bidding registers written at 0x68 (change of state), 0x69 (address match), 0x6A (flow control), 0x6B (break), 0x6C (counter/timer) and 0x6D (loopback error). The threshold is written at 0x60. A source with its request low, or with a priority of 0, does not bid.
- R3: The bid with the largest key wins. When keys are equal, the source earlier in this list wins: channel 0 before channel 1; within a channel, receiver, transmitter, change of state, address match, flow control, break, loopback error; counter/timer 0 and then 1 last of all. The winner is registered, so an input change shows at `irq_n` one clock later.
- R4: Outside watchdog mode, `irq_n` is 0 exactly when a winner exists and its priority is strictly greater than the threshold.
- R5: While any `wdog_pend` bit is 1, only receiver bids arbitrate and the threshold is ignored. `irq_n` is then 0 exactly when some receiver bids.
- R6: An update made while `irq_n` is 1 loads 0x00 into `cur_irq`.
- R7: An `iack` pulse, or a write of any data to address 0x61, loads the winner's byte into `cur_irq` on that clock edge. Byte layouts: receiver {1, err, count[4:0], ch}; transmitter {01, count[4:0], ch}; other sources {00, type[4:0], ch}. Type codes: change of state 1, address match 2, flow control 3, break 5, counter/timer 6, loopback error 7. For a counter/timer, bit 0 is the timer number.
- R8: Apart from R6 and R7, `cur_irq` keeps its value. Input changes and writes to other addresses leave it unchanged, and a write to 0x61 alters neither the threshold nor any bidding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| iack | input | 1 | One-cycle pulse at the start of an interrupt acknowledge |
| rx_req | input | 2 | Receiver interrupt pending, one bit per channel |
| rx_err | input | 2 | Receiver data carries errors, per channel |
| rx_prio | input | 16 | Receiver priority, 8 bits per channel |
| rx_cnt | input | 10 | Receiver count code, 5 bits per channel |
| tx_req | input | 2 | Transmitter interrupt pending, per channel |
| tx_prio | input | 16 | Transmitter priority, 8 bits per channel |
| tx_cnt | input | 10 | Transmitter count code, 5 bits per channel |
| cos_req | input | 2 | Change-of-state pending, per channel |
| adr_req | input | 2 | Address match pending, per channel |
| flow_req | input | 2 | Flow-control status pending, per channel |
| brk_req | input | 2 | Break change pending, per channel |
| lbe_req | input | 2 | Loopback error pending, per channel |
| wdog_pend | input | 2 | Receive watchdog pending, per channel |
| ct_req | input | 2 | Counter/timer event pending, per timer |
| irq_n | output | 1 | Active-low interrupt request |
| cur_irq | output | 8 | Frozen current-interrupt byte |

## Verification
Equal-key ties are the hardest case to reach. Break and loopback error on the same channel carry the same code, so only list order separates them when their bidding registers hold the same value, and a counter/timer can tie with a channel-1 source. The bench programs all bidding registers and data-source priorities to one value and then drops requests one at a time. Random patterns that reuse a small set of priority values add many more ties. Watchdog mode is driven with a high threshold, a low-priority receiver and high-priority non-receiver sources, so that the bypass and the receiver-only filter are each the only thing that changes the outcome.

// File: rtl/irq_arb_pkg.sv
// Package irq_arb_pkg
// Shared widths, bid record, type codes and bidding-register slots
// for the interrupt bid arbiter.
package irq_arb_pkg;
    localparam int PRIO_W = 8;
    localparam int CODE_W = 3;
    localparam int KEY_W  = PRIO_W + CODE_W;
    localparam int CNT_W  = 5;
    localparam int BYTE_W = 8;
    localparam int NBCR   = 6;
    localparam int PER_CH = 7;

    typedef struct packed {
        logic              vld;
        logic [KEY_W-1:0]  key;
        logic [BYTE_W-1:0] info;
    } bid_t;

    // Type codes placed in the current-interrupt byte for non-data sources
    localparam logic [CNT_W-1:0] TY_COS  = 5'd1;
    localparam logic [CNT_W-1:0] TY_ADR  = 5'd2;
    localparam logic [CNT_W-1:0] TY_FLOW = 5'd3;
    localparam logic [CNT_W-1:0] TY_BRK  = 5'd5;
    localparam logic [CNT_W-1:0] TY_CT   = 5'd6;
    localparam logic [CNT_W-1:0] TY_LBE  = 5'd7;

    // Bidding-register slots (offset from the bidding base address)
    localparam int S_COS  = 0;
    localparam int S_ADR  = 1;
    localparam int S_FLOW = 2;
    localparam int S_BRK  = 3;
    localparam int S_CT   = 4;
    localparam int S_LBE  = 5;
endpackage

// File: rtl/irq_bid_regs.sv
// Module irq_bid_regs
// Holds the threshold and the bidding registers and decodes the update
// command. Assumes single-cycle write strobes; the update command is a
// decode only, so its data is discarded.
module irq_bid_regs
    import irq_arb_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] THR_ADDR = 8'h60,
    parameter logic [ADDR_W-1:0] UPD_ADDR = 8'h61,
    parameter logic [ADDR_W-1:0] BCR_BASE = 8'h68
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [BYTE_W-1:0]             wr_data,
    output logic [PRIO_W-1:0]             thr,
    output logic [NBCR-1:0][PRIO_W-1:0]   bcr,
    output logic                          upd_stb
);
    // Register writes for the threshold and the bidding registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr <= '0;
            bcr <= '0;
        end else if (wr_en) begin
            if (wr_addr == THR_ADDR) thr <= wr_data;
            for (int k = 0; k < NBCR; k++) begin
                if (wr_addr == BCR_BASE + ADDR_W'(k)) bcr[k] <= wr_data;
            end
        end
    end

    // Update-command decode
    assign upd_stb = wr_en && (wr_addr == UPD_ADDR);
endmodule

// File: rtl/irq_bid_collect.sv
// Module irq_bid_collect
// Builds one bid record per source: the key and the byte it would
// present. Assumes at most two channels and two timers, since bit 0 of
// the code and of the byte names them. In watchdog mode every
// non-receiver source is masked.
module irq_bid_collect
    import irq_arb_pkg::*;
#(
    parameter int NCH  = 2,
    parameter int NCT  = 2,
    parameter int NSRC = PER_CH * NCH + NCT
) (
    input  logic                        wdog_any,
    input  logic [NCH-1:0]              rx_req,
    input  logic [NCH-1:0]              rx_err,
    input  logic [NCH*PRIO_W-1:0]       rx_prio,
    input  logic [NCH*CNT_W-1:0]        rx_cnt,
    input  logic [NCH-1:0]              tx_req,
    input  logic [NCH*PRIO_W-1:0]       tx_prio,
    input  logic [NCH*CNT_W-1:0]        tx_cnt,
    input  logic [NCH-1:0]              cos_req,
    input  logic [NCH-1:0]              adr_req,
    input  logic [NCH-1:0]              flow_req,
    input  logic [NCH-1:0]              brk_req,
    input  logic [NCH-1:0]              lbe_req,
    input  logic [NCT-1:0]              ct_req,
    input  logic [NBCR-1:0][PRIO_W-1:0] bcr,
    output bid_t [NSRC-1:0]             bids
);
    // Pack one bid; a zero priority or a low request never bids
    function automatic bid_t mk(input logic req, input logic [PRIO_W-1:0] p,
                                input logic [CODE_W-1:0] c, input logic [BYTE_W-1:0] v);
        bid_t b;
        b.vld  = req && (p != '0);
        b.key  = {p, c};
        b.info = v;
        return b;
    endfunction

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        localparam int   B  = ch * PER_CH;
        localparam logic CB = 1'(ch);
        logic oth;
        assign oth = !wdog_any;
        assign bids[B+0] = mk(rx_req[ch], rx_prio[ch*PRIO_W +: PRIO_W], {2'b11, CB},
                              {1'b1, rx_err[ch], rx_cnt[ch*CNT_W +: CNT_W], CB});
        assign bids[B+1] = mk(tx_req[ch] && oth, tx_prio[ch*PRIO_W +: PRIO_W], {2'b10, CB},
                              {2'b01, tx_cnt[ch*CNT_W +: CNT_W], CB});
        assign bids[B+2] = mk(cos_req[ch]  && oth, bcr[S_COS],  {2'b00, CB}, {2'b00, TY_COS,  CB});
        assign bids[B+3] = mk(adr_req[ch]  && oth, bcr[S_ADR],  {2'b00, CB}, {2'b00, TY_ADR,  CB});
        assign bids[B+4] = mk(flow_req[ch] && oth, bcr[S_FLOW], {2'b00, CB}, {2'b00, TY_FLOW, CB});
        assign bids[B+5] = mk(brk_req[ch]  && oth, bcr[S_BRK],  {2'b00, CB}, {2'b00, TY_BRK,  CB});
        assign bids[B+6] = mk(lbe_req[ch]  && oth, bcr[S_LBE],  {2'b00, CB}, {2'b00, TY_LBE,  CB});
    end

    for (genvar k = 0; k < NCT; k++) begin : g_ct
        localparam logic KB = 1'(k);
        assign bids[PER_CH*NCH + k] = mk(ct_req[k] && !wdog_any, bcr[S_CT], {2'b00, KB},
                                         {2'b00, TY_CT, KB});
    end
endmodule

// File: rtl/irq_bid_max.sv
// Module irq_bid_max
// One-cycle registered maximum search over all bids. Only a strictly
// larger key displaces the current best, so the earlier source in the
// list keeps an equal-key tie. The watchdog mode is registered with the
// winner so that the two stay aligned.
module irq_bid_max
    import irq_arb_pkg::*;
#(
    parameter int NSRC = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  bid_t [NSRC-1:0] bids,
    input  logic            wdog_any,
    output bid_t            win,
    output logic            wdog_q
);
    bid_t best;

    // Linear scan for the largest valid key
    always_comb begin
        best = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (bids[i].vld && (!best.vld || bids[i].key > best.key)) best = bids[i];
        end
    end

    // Register the winner and the mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win    <= '0;
            wdog_q <= 1'b0;
        end else begin
            win    <= best;
            wdog_q <= wdog_any;
        end
    end
endmodule

// File: rtl/irq_bid_arbiter.sv
// Module irq_bid_arbiter (top)
// Gates the registered winner with the threshold to form the interrupt
// request, and freezes the winner's byte on acknowledge or on the update
// command. Assumes NCH and NCT are at most 2.
module irq_bid_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int NCT    = 2,
    parameter int ADDR_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [7:0]             wr_data,
    input  logic                   iack,
    input  logic [NCH-1:0]         rx_req,
    input  logic [NCH-1:0]         rx_err,
    input  logic [NCH*8-1:0]       rx_prio,
    input  logic [NCH*5-1:0]       rx_cnt,
    input  logic [NCH-1:0]         tx_req,
    input  logic [NCH*8-1:0]       tx_prio,
    input  logic [NCH*5-1:0]       tx_cnt,
    input  logic [NCH-1:0]         cos_req,
    input  logic [NCH-1:0]         adr_req,
    input  logic [NCH-1:0]         flow_req,
    input  logic [NCH-1:0]         brk_req,
    input  logic [NCH-1:0]         lbe_req,
    input  logic [NCH-1:0]         wdog_pend,
    input  logic [NCT-1:0]         ct_req,
    output logic                   irq_n,
    output logic [7:0]             cur_irq
);
    localparam int NSRC = PER_CH * NCH + NCT;

    logic [PRIO_W-1:0]           thr;
    logic [NBCR-1:0][PRIO_W-1:0] bcr;
    logic                        upd_stb;
    logic                        wdog_any;
    logic                        wdog_q;
    bid_t [NSRC-1:0]             bids;
    bid_t                        win;
    logic                        win_vld;
    logic [PRIO_W-1:0]           win_prio;
    logic [BYTE_W-1:0]           win_info;
    logic                        qual;

    assign wdog_any = |wdog_pend;

    irq_bid_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .thr(thr), .bcr(bcr), .upd_stb(upd_stb)
    );

    irq_bid_collect #(.NCH(NCH), .NCT(NCT), .NSRC(NSRC)) u_collect (
        .wdog_any(wdog_any), .rx_req(rx_req), .rx_err(rx_err), .rx_prio(rx_prio),
        .rx_cnt(rx_cnt), .tx_req(tx_req), .tx_prio(tx_prio), .tx_cnt(tx_cnt),
        .cos_req(cos_req), .adr_req(adr_req), .flow_req(flow_req),
        .brk_req(brk_req), .lbe_req(lbe_req), .ct_req(ct_req), .bcr(bcr),
        .bids(bids)
    );

    irq_bid_max #(.NSRC(NSRC)) u_max (
        .clk(clk), .rst_n(rst_n), .bids(bids), .wdog_any(wdog_any),
        .win(win), .wdog_q(wdog_q)
    );

    assign win_vld  = win.vld;
    assign win_prio = win.key[KEY_W-1 -: PRIO_W];
    assign win_info = win.info;

    // Winner qualifies if it beats the threshold, or in watchdog mode
    assign qual  = win_vld && (wdog_q || (win_prio > thr));
    assign irq_n = !qual;

    // Freeze the qualifying winner, or zero, on acknowledge or update
    always_ff @(posedge clk) begin
        if (!rst_n)              cur_irq <= '0;
        else if (iack || upd_stb) cur_irq <= qual ? win_info : '0;
    end
endmodule

// File: rtl/irq_arb_checks.sv
// Module irq_arb_checks
// Property checker for irq_bid_arbiter, attached by the bind below.
module irq_arb_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       iack,
    input logic       upd_stb,
    input logic       irq_n,
    input logic [7:0] cur_irq,
    input logic       win_vld,
    input logic [7:0] win_prio,
    input logic [7:0] win_info,
    input logic       wdog_q,
    input logic [7:0] thr
);
    a_r8_cir_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !(iack || upd_stb) |=> $stable(cur_irq));

    a_r6_cir_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (iack || upd_stb) && irq_n |=> cur_irq == 8'h00);

    a_r7_cir_load: assert property (@(posedge clk) disable iff (!rst_n)
        (iack || upd_stb) && !irq_n |=> cur_irq == $past(win_info));

    a_r4_irq_thr: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n && !wdog_q |-> win_prio > thr);

    a_r5_wdog_rx_only: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_q && win_vld |-> win_info[7] && !irq_n);

    a_r1_no_winner_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !win_vld |-> irq_n);
endmodule

bind irq_bid_arbiter irq_arb_checks u_chk (
    .clk(clk), .rst_n(rst_n), .iack(iack), .upd_stb(upd_stb), .irq_n(irq_n),
    .cur_irq(cur_irq), .win_vld(win_vld), .win_prio(win_prio),
    .win_info(win_info), .wdog_q(wdog_q), .thr(thr)
);

// File: tb/irq_bid_arbiter_bench.sv
`timescale 1ns/1ps
module irq_bid_arbiter_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] wr_addr = '0, wr_data = '0;
    logic iack = 1'b0;
    logic [1:0] rx_req = '0, rx_err = '0, tx_req = '0;
    logic [15:0] rx_prio = '0, tx_prio = '0;
    logic [9:0] rx_cnt = '0, tx_cnt = '0;
    logic [1:0] cos_req = '0, adr_req = '0, flow_req = '0, brk_req = '0, lbe_req = '0;
    logic [1:0] wdog_pend = '0, ct_req = '0;
    logic irq_n;
    logic [7:0] cur_irq;

    int checks = 0, failures = 0;
    bit done = 0;
    bit use_iack = 0;
    logic [7:0] thr_m = '0;
    logic [7:0] bm [6] = '{default: 8'h00};
    logic [7:0] held;

    always #4 clk = ~clk;

    irq_bid_arbiter u_irq_bid_arbiter (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .iack(iack), .rx_req(rx_req), .rx_err(rx_err), .rx_prio(rx_prio), .rx_cnt(rx_cnt),
        .tx_req(tx_req), .tx_prio(tx_prio), .tx_cnt(tx_cnt), .cos_req(cos_req),
        .adr_req(adr_req), .flow_req(flow_req), .brk_req(brk_req), .lbe_req(lbe_req),
        .wdog_pend(wdog_pend), .ct_req(ct_req), .irq_n(irq_n), .cur_irq(cur_irq)
    );

    task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Expected winner from the requirement rules (R2 R3 R4 R5)
    task automatic model(output logic q, output logic [7:0] c);
        logic bv = 0;
        logic [10:0] bk = '0;
        logic [7:0] bc = '0;
        logic wd = |wdog_pend;
        for (int i = 0; i < 16; i++) begin
            logic r;
            logic [7:0] p, cv;
            logic [2:0] cd;
            int ch, s;
            if (i < 14) begin ch = i / 7; s = i % 7; end
            else begin ch = i - 14; s = 7; end
            cd = {2'b00, ch[0]};
            case (s)
                0: begin r = rx_req[ch]; p = rx_prio[ch*8 +: 8]; cd = {2'b11, ch[0]};
                         cv = {1'b1, rx_err[ch], rx_cnt[ch*5 +: 5], ch[0]}; end
                1: begin r = tx_req[ch] && !wd; p = tx_prio[ch*8 +: 8]; cd = {2'b10, ch[0]};
                         cv = {2'b01, tx_cnt[ch*5 +: 5], ch[0]}; end
                2: begin r = cos_req[ch] && !wd;  p = bm[0]; cv = {2'b00, 5'd1, ch[0]}; end
                3: begin r = adr_req[ch] && !wd;  p = bm[1]; cv = {2'b00, 5'd2, ch[0]}; end
                4: begin r = flow_req[ch] && !wd; p = bm[2]; cv = {2'b00, 5'd3, ch[0]}; end
                5: begin r = brk_req[ch] && !wd;  p = bm[3]; cv = {2'b00, 5'd5, ch[0]}; end
                6: begin r = lbe_req[ch] && !wd;  p = bm[5]; cv = {2'b00, 5'd7, ch[0]}; end
                default: begin r = ct_req[ch] && !wd; p = bm[4]; cv = {2'b00, 5'd6, ch[0]}; end
            endcase
            if (r && p != 0 && (!bv || {p, cd} > bk)) begin
                bv = 1; bk = {p, cd}; bc = cv;
            end
        end
        q = bv && (wd || bk[10:3] > thr_m);
        c = q ? bc : 8'h00;
    endtask

    // Register write; called at a falling edge
    task automatic wr(logic [7:0] a, logic [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
        if (a == 8'h60) thr_m = d;
        if (a >= 8'h68 && a <= 8'h6D) bm[a - 8'h68] = d;
    endtask

    // Let the winner register, check the request, then update and check the byte
    task automatic step(string tag);
        logic q;
        logic [7:0] c;
        @(negedge clk);
        model(q, c);
        check8({tag, " irq_n"}, {7'b0, irq_n}, {7'b0, !q});
        if (use_iack) iack = 1;
        else begin wr_en = 1; wr_addr = 8'h61; wr_data = 8'($urandom); end
        @(negedge clk);
        iack = 0; wr_en = 0;
        check8({tag, " cur_irq"}, cur_irq, c);
        use_iack = !use_iack;
    endtask

    task automatic clear_src();
        rx_req = 0; tx_req = 0; cos_req = 0; adr_req = 0; flow_req = 0;
        brk_req = 0; lbe_req = 0; ct_req = 0; wdog_pend = 0; rx_err = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset values
        check8("R1 reset irq_n", {7'b0, irq_n}, 8'h01);
        check8("R1 reset cur_irq", cur_irq, 8'h00);
        // R1: all non-data sources request with bidding registers at zero
        cos_req = 3; adr_req = 3; flow_req = 3; brk_req = 3; lbe_req = 3; ct_req = 3;
        step("R1 zero bcr");
        clear_src();

        // R4 R6: threshold sweep around a single receiver bid
        rx_req = 2'b10; rx_prio = 16'h4000; rx_cnt = 10'b00101_00000;
        for (int t = 8'h3C; t <= 8'h44; t++) begin
            wr(8'h60, 8'(t));
            step($sformatf("R4 R6 thr=%02h", t));
        end
        rx_err = 2'b10;
        step("R7 rx with errors");
        clear_src();

        // R2 R7: each non-data type alone on each channel and timer
        wr(8'h60, 8'h00);
        for (int k = 0; k < 6; k++) wr(8'(8'h68 + k), 8'(8'h10 + 8'h11 * k));
        for (int ch = 0; ch < 2; ch++) begin
            for (int s = 0; s < 6; s++) begin
                clear_src();
                case (s)
                    0: cos_req[ch] = 1;
                    1: adr_req[ch] = 1;
                    2: flow_req[ch] = 1;
                    3: brk_req[ch] = 1;
                    4: lbe_req[ch] = 1;
                    default: ct_req[ch] = 1;
                endcase
                step($sformatf("R2 R7 type s=%0d ch=%0d", s, ch));
            end
        end
        clear_src();
        tx_req = 2'b01; tx_prio = 16'h0077; tx_cnt = 10'b00000_11111;
        step("R7 transmitter");
        clear_src();

        // R3: equal keys everywhere, drop requests one at a time
        for (int k = 0; k < 6; k++) wr(8'(8'h68 + k), 8'h50);
        rx_prio = 16'h5050; tx_prio = 16'h5050;
        rx_req = 3; tx_req = 3; cos_req = 3; adr_req = 3; flow_req = 3;
        brk_req = 3; lbe_req = 3; ct_req = 3;
        for (int d = 0; d < 16; d++) begin
            step($sformatf("R3 tie drop=%0d", d));
            case (d)
                0: rx_req[1] = 0;  1: rx_req[0] = 0;  2: tx_req[1] = 0;  3: tx_req[0] = 0;
                4: cos_req[1] = 0; 5: adr_req[1] = 0; 6: flow_req[1] = 0; 7: brk_req[1] = 0;
                8: lbe_req[1] = 0; 9: ct_req[1] = 0;  10: cos_req[0] = 0; 11: adr_req[0] = 0;
                12: flow_req[0] = 0; 13: brk_req[0] = 0; 14: lbe_req[0] = 0; default: ct_req[0] = 0;
            endcase
        end
        clear_src();

        // R5: watchdog bypasses threshold and masks non-receivers
        wr(8'h60, 8'hF0);
        rx_req = 2'b01; rx_prio = 16'h0002; rx_cnt = 10'd3;
        tx_req = 2'b10; tx_prio = 16'hFF00; cos_req = 3;
        wr(8'h68, 8'hFE);
        step("R5 no watchdog");
        wdog_pend = 2'b10;
        step("R5 watchdog rx wins");
        rx_req = 0;
        step("R5 watchdog no rx");
        clear_src();

        // R8: frozen byte across input changes and other writes
        wr(8'h60, 8'h00);
        rx_req = 2'b01; rx_prio = 16'h0033;
        step("R8 load");
        held = cur_irq;
        rx_req = 2'b10; rx_prio = 16'h9900; tx_req = 3; tx_prio = 16'hAAAA;
        repeat (3) @(negedge clk);
        check8("R8 frozen inputs", cur_irq, held);
        wr(8'h60, 8'h05);
        wr(8'h6B, 8'h44);
        @(negedge clk);
        check8("R8 frozen writes", cur_irq, held);
        wr(8'h61, 8'hFF);
        wr(8'h61, 8'h00);
        clear_src();
        brk_req = 2'b01; rx_req = 2'b01; rx_prio = 16'h0044;
        step("R8 update leaves bcr and thr");
        clear_src();

        // R3: random patterns with small value sets to force ties
        for (int n = 0; n < 300; n++) begin
            if (n % 25 == 0) begin
                for (int k = 0; k < 6; k++) wr(8'(8'h68 + k), 8'(($urandom % 4) * 8'h20));
                wr(8'h60, 8'($urandom % 8'h70));
            end
            rx_req = 2'($urandom); rx_err = 2'($urandom); tx_req = 2'($urandom);
            rx_prio = {8'(($urandom % 4) * 8'h20), 8'(($urandom % 4) * 8'h20)};
            tx_prio = {8'(($urandom % 4) * 8'h20), 8'(($urandom % 4) * 8'h20)};
            rx_cnt = 10'($urandom); tx_cnt = 10'($urandom);
            cos_req = 2'($urandom); adr_req = 2'($urandom); flow_req = 2'($urandom);
            brk_req = 2'($urandom); lbe_req = 2'($urandom); ct_req = 2'($urandom);
            wdog_pend = ($urandom % 8 == 0) ? 2'($urandom) : 2'b00;
            step($sformatf("R3 random n=%0d", n));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule